// File: doc/BRIEF.md
# Doorbell-Handshake Command Mailbox

This block is a device-side register file that a host reaches over a byte-wide bus. It holds one outbound command slot and one inbound completion slot. The two sides coordinate through a pair of two-bit doorbells. In the local doorbell the host sets bits and the device clears them. In the system doorbell the device sets bits and the host clears them by writing ones. Bit 0 of each doorbell means "busy": work has been handed over, or a completion has been posted. Bit 1 means "clear": the slot is free, or the slot is reported full.

To submit a command, the host fills the list address and list length bytes and then sets the busy bit of the local doorbell. The device sees a one-cycle command pulse along with the captured address and length. Later it posts a completion address and a status byte through a valid/ready port. That post raises system doorbell bit 0, which drives the interrupt when both enable masks allow it. The host clears the bit, reads the completion, and the slot can be used again. Further posts are held off while bit 0 is still set.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset every register and both doorbells read 0, `irq` and `cmdValid` are 0, and `devCplReady` is 1.
- R2: The plain byte registers read back the last value written to them: interrupt enable 0xC89, local mask 0xC8C, system mask 0xC8E, tag 0xC97, list address bytes 0xC90..0xC93 (least significant byte first) and list length bytes 0xC94..0xC95. Reads of an unmapped offset such as 0xC8A return 0.
- R3: System doorbell (0xC8F) bit 0 (0x01) is set by an accepted completion. Bit 1 (0x02) is set by a `devFullSet` pulse. A host write clears each bit written as 1, so 0xFD clears bit 0 and leaves bit 1. A device set in the same cycle as a host clear wins. Bits 7:2 read 0.
- R4: Local doorbell (0xC8D): a host write ORs data bits 1:0 into the doorbell, and `devLocalClr` clears the bits it names. When a set and a clear of one bit meet in the same cycle, the set wins. The doorbell is also visible on `localBell`.
- R5: A host write that sets local bit 0 while it is 0 gives a `cmdValid` pulse of exactly one cycle, in the cycle after the write. No pulse follows a write while bit 0 is already set. `cmdAddr` and `cmdLen` always show the list address and list length registers.
- R6: A completion accepted while `devCplValid` and `devCplReady` are both 1 stores the address at 0xC98..0xC9B (least significant byte first) and the status at 0xC9E, and sets system bit 0 one cycle later.
- R7: `devCplReady` is 0 exactly while system bit 0 is set. A post presented during that time leaves the completion registers unchanged and is accepted in the first cycle after the host clears bit 0.
- R8: `irq` equals system doorbell bit 0 AND system mask bit 0 AND interrupt enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostAddr | input | ADDR_W | Host byte address |
| hostWrEn | input | 1 | Host write strobe for one byte |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Combinational read data for hostAddr |
| cmdValid | output | 1 | One-cycle pulse: a new command was handed over |
| cmdAddr | output | 32 | List address register |
| cmdLen | output | 16 | List length register |
| localBell | output | 2 | Local doorbell state |
| devLocalClr | input | 2 | Device clears these local doorbell bits |
| devFullSet | input | 1 | Device sets system doorbell bit 1 |
| devCplValid | input | 1 | Device offers a completion |
| devCplAddr | input | 32 | Completion address |
| devCplStatus | input | 8 | Completion status byte |
| devCplReady | output | 1 | Completion slot is free |
| irq | output | 1 | Host interrupt |

## Verification
On every cycle the assertions check four things: that `cmdValid` lasts one cycle and coincides with a set local busy bit, that system bit 0 only falls after a host write of a one to it, and that the list and completion registers move only on their write or capture strobes. They also check that `irq` is never high while the completion slot is free. A reference model in the bench shadows every register and doorbell and compares the read data and all outputs each cycle. Only the directed scenarios can show the ordering effects: the set-versus-clear collisions, a post held off across a host clear and then accepted one cycle later, and the mask sequence that turns the interrupt on and off.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_BYTES = 4;
  localparam int LEN_BYTES  = 2;

  // host-visible byte offsets (software decodes these)
  localparam int OFF_INT_EN    = 'hC89;
  localparam int OFF_LOC_MASK  = 'hC8C;
  localparam int OFF_LOC_BELL  = 'hC8D;
  localparam int OFF_SYS_MASK  = 'hC8E;
  localparam int OFF_SYS_BELL  = 'hC8F;
  localparam int OFF_LIST_ADDR = 'hC90;
  localparam int OFF_LIST_LEN  = 'hC94;
  localparam int OFF_TAG       = 'hC97;
  localparam int OFF_CPL_ADDR  = 'hC98;
  localparam int OFF_CPL_STAT  = 'hC9E;

  // strobes from control to datapath
  typedef struct packed {
    logic                  intEn;
    logic                  locMask;
    logic                  sysMask;
    logic                  tag;
    logic [ADDR_BYTES-1:0] listAddr;
    logic [LEN_BYTES-1:0]  listLen;
    logic                  cplLoad;
  } mboxStb_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [1:0]        bellWrData,
  input  logic [1:0]        devLocalClr,
  input  logic              devFullSet,
  input  logic              devCplValid,
  input  logic              intEnBit,
  input  logic              sysMaskBit,
  output mboxStb_t          stb,
  output logic [1:0]        sysBell,
  output logic [1:0]        locBell,
  output logic              cmdValid,
  output logic              cplReady,
  output logic              irq
);
  logic [1:0] sysClr;
  logic [1:0] locSet;
  logic       cplAccept;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign cplAccept = devCplValid && !sysBell[0];
  assign cplReady  = !sysBell[0];
  assign irq       = sysBell[0] && sysMaskBit && intEnBit;

  always_comb begin
    stb         = '0;
    stb.intEn   = hostWrEn && hit(hostAddr, OFF_INT_EN);
    stb.locMask = hostWrEn && hit(hostAddr, OFF_LOC_MASK);
    stb.sysMask = hostWrEn && hit(hostAddr, OFF_SYS_MASK);
    stb.tag     = hostWrEn && hit(hostAddr, OFF_TAG);
    for (int i = 0; i < ADDR_BYTES; i++)
      stb.listAddr[i] = hostWrEn && hit(hostAddr, OFF_LIST_ADDR + i);
    for (int i = 0; i < LEN_BYTES; i++)
      stb.listLen[i] = hostWrEn && hit(hostAddr, OFF_LIST_LEN + i);
    stb.cplLoad = cplAccept;
    sysClr = (hostWrEn && hit(hostAddr, OFF_SYS_BELL)) ? bellWrData : 2'b00;
    locSet = (hostWrEn && hit(hostAddr, OFF_LOC_BELL)) ? bellWrData : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysBell  <= '0;
      locBell  <= '0;
      cmdValid <= 1'b0;
    end else begin
      sysBell  <= (sysBell & ~sysClr) | {devFullSet, cplAccept};
      locBell  <= (locBell & ~devLocalClr) | locSet;
      cmdValid <= locSet[0] && !locBell[0];
    end
  end

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R5
  AST_CMD_WITH_BELL: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> locBell[0]); // R5
  AST_SYS_FALL_BY_HOST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysBell[0]) |-> $past(hostWrEn && hit(hostAddr, OFF_SYS_BELL) && bellWrData[0])); // R3
  AST_IRQ_SLOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !cplReady); // R8
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mboxStb_t                 stb,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [DATA_W-1:0]        hostWrData,
  input  logic [1:0]               sysBell,
  input  logic [1:0]               locBell,
  input  logic [8*ADDR_BYTES-1:0]  devCplAddr,
  input  logic [DATA_W-1:0]        devCplStatus,
  output logic [DATA_W-1:0]        hostRdData,
  output logic [8*ADDR_BYTES-1:0]  cmdAddr,
  output logic [8*LEN_BYTES-1:0]   cmdLen,
  output logic                     intEnBit,
  output logic                     sysMaskBit
);
  logic [DATA_W-1:0] intEnQ, locMaskQ, sysMaskQ, tagQ, cplStatQ;
  logic [ADDR_BYTES-1:0][7:0] listAddrQ, cplAddrQ;
  logic [LEN_BYTES-1:0][7:0]  listLenQ;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign cmdAddr    = listAddrQ;
  assign cmdLen     = listLenQ;
  assign intEnBit   = intEnQ[0];
  assign sysMaskBit = sysMaskQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnQ    <= '0;
      locMaskQ  <= '0;
      sysMaskQ  <= '0;
      tagQ      <= '0;
      listAddrQ <= '0;
      listLenQ  <= '0;
      cplAddrQ  <= '0;
      cplStatQ  <= '0;
    end else begin
      if (stb.intEn)   intEnQ   <= hostWrData;
      if (stb.locMask) locMaskQ <= hostWrData;
      if (stb.sysMask) sysMaskQ <= hostWrData;
      if (stb.tag)     tagQ     <= hostWrData;
      for (int i = 0; i < ADDR_BYTES; i++)
        if (stb.listAddr[i]) listAddrQ[i] <= hostWrData;
      for (int i = 0; i < LEN_BYTES; i++)
        if (stb.listLen[i]) listLenQ[i] <= hostWrData;
      if (stb.cplLoad) begin
        cplAddrQ <= devCplAddr;
        cplStatQ <= devCplStatus;
      end
    end
  end

  always_comb begin
    hostRdData = '0;
    if (hit(hostAddr, OFF_INT_EN))   hostRdData = intEnQ;
    if (hit(hostAddr, OFF_LOC_MASK)) hostRdData = locMaskQ;
    if (hit(hostAddr, OFF_LOC_BELL)) hostRdData = {6'b0, locBell};
    if (hit(hostAddr, OFF_SYS_MASK)) hostRdData = sysMaskQ;
    if (hit(hostAddr, OFF_SYS_BELL)) hostRdData = {6'b0, sysBell};
    if (hit(hostAddr, OFF_TAG))      hostRdData = tagQ;
    if (hit(hostAddr, OFF_CPL_STAT)) hostRdData = cplStatQ;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (hit(hostAddr, OFF_LIST_ADDR + i)) hostRdData = listAddrQ[i];
      if (hit(hostAddr, OFF_CPL_ADDR + i))  hostRdData = cplAddrQ[i];
    end
    for (int i = 0; i < LEN_BYTES; i++)
      if (hit(hostAddr, OFF_LIST_LEN + i)) hostRdData = listLenQ[i];
  end

  AST_LIST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(|stb.listAddr) |=> $stable(listAddrQ)); // R2
  AST_CPL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cplLoad |=> $stable({cplAddrQ, cplStatQ})); // R7
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  output logic              cmdValid,
  output logic [31:0]       cmdAddr,
  output logic [15:0]       cmdLen,
  output logic [1:0]        localBell,
  input  logic [1:0]        devLocalClr,
  input  logic              devFullSet,
  input  logic              devCplValid,
  input  logic [31:0]       devCplAddr,
  input  logic [7:0]        devCplStatus,
  output logic              devCplReady,
  output logic              irq
);
  mboxStb_t   stb;
  logic [1:0] sysBell;
  logic       intEnBit, sysMaskBit;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .bellWrData(hostWrData[1:0]), .devLocalClr(devLocalClr),
    .devFullSet(devFullSet), .devCplValid(devCplValid),
    .intEnBit(intEnBit), .sysMaskBit(sysMaskBit), .stb(stb),
    .sysBell(sysBell), .locBell(localBell), .cmdValid(cmdValid),
    .cplReady(devCplReady), .irq(irq)
  );

  mbox_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .sysBell(sysBell), .locBell(localBell),
    .devCplAddr(devCplAddr), .devCplStatus(devCplStatus),
    .hostRdData(hostRdData), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .intEnBit(intEnBit), .sysMaskBit(sysMaskBit)
  );
endmodule

// File: tb/mbox_doorbell_bench.sv
module mbox_doorbell_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        cmdValid, devCplReady, irq;
  logic [31:0] cmdAddr;
  logic [15:0] cmdLen;
  logic [1:0]  localBell;
  logic [1:0]  devLocalClr = '0;
  logic        devFullSet = 1'b0;
  logic        devCplValid = 1'b0;
  logic [31:0] devCplAddr = '0;
  logic [7:0]  devCplStatus = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbox_doorbell u_mbox_doorbell (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .cmdValid(cmdValid),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .localBell(localBell),
    .devLocalClr(devLocalClr), .devFullSet(devFullSet),
    .devCplValid(devCplValid), .devCplAddr(devCplAddr),
    .devCplStatus(devCplStatus), .devCplReady(devCplReady), .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [7:0]  mIntEn, mLocMask, mSysMask, mTag, mCplStat;
  logic [7:0]  mList [0:5];
  logic [31:0] mCplAddr;
  logic [1:0]  mSys, mLoc;
  logic        mCmdV;
  logic [1:0]  tClr, tSet;
  logic        tAcc;

  always @(posedge clk) begin
    if (!rstN) begin
      mIntEn = 0; mLocMask = 0; mSysMask = 0; mTag = 0; mCplStat = 0;
      for (int i = 0; i < 6; i++) mList[i] = 0;
      mCplAddr = 0; mSys = 0; mLoc = 0; mCmdV = 0;
    end else begin
      tClr = 0; tSet = 0;
      if (hostWrEn) begin
        case (hostAddr)
          12'hC89: mIntEn = hostWrData;
          12'hC8C: mLocMask = hostWrData;
          12'hC8D: tSet = hostWrData[1:0];
          12'hC8E: mSysMask = hostWrData;
          12'hC8F: tClr = hostWrData[1:0];
          12'hC97: mTag = hostWrData;
          default: if (hostAddr >= 12'hC90 && hostAddr <= 12'hC95)
                     mList[hostAddr - 12'hC90] = hostWrData;
        endcase
      end
      tAcc = devCplValid && !mSys[0];
      if (tAcc) begin mCplAddr = devCplAddr; mCplStat = devCplStatus; end
      mCmdV = tSet[0] && !mLoc[0];
      mSys = (mSys & ~tClr) | {devFullSet, tAcc};
      mLoc = (mLoc & ~devLocalClr) | tSet;
    end
  end

  function automatic logic [7:0] mRead(input logic [11:0] a);
    if (a == 12'hC89) return mIntEn;
    if (a == 12'hC8C) return mLocMask;
    if (a == 12'hC8D) return {6'b0, mLoc};
    if (a == 12'hC8E) return mSysMask;
    if (a == 12'hC8F) return {6'b0, mSys};
    if (a == 12'hC97) return mTag;
    if (a == 12'hC9E) return mCplStat;
    if (a >= 12'hC90 && a <= 12'hC95) return mList[a - 12'hC90];
    if (a >= 12'hC98 && a <= 12'hC9B) return mCplAddr[8*(a-12'hC98) +: 8];
    return 8'h00;
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    if (a == 12'hC8F) return "R3";
    if (a == 12'hC8D) return "R4";
    if (a >= 12'hC98 && a <= 12'hC9E) return "R6";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(tagFor(hostAddr), hostRdData, mRead(hostAddr));
      chk("R8", irq, mSys[0] & mSysMask[0] & mIntEn[0]);
      chk("R7", devCplReady, !mSys[0]);
      chk("R5", cmdValid, mCmdV);
      chk("R4", localBell, mLoc);
      chk("R5", cmdAddr, {mList[3], mList[2], mList[1], mList[0]});
      chk("R5", cmdLen, {mList[5], mList[4]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk); #1;
    hostWrEn = 0; devLocalClr = 0; devFullSet = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1;
    tick();
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string req);
    hostAddr = a; #1;
    chk(req, hostRdData, exp);
  endtask

  task automatic report();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    // R1 reset state
    rd(12'hC8F, 8'h00, "R1"); rd(12'hC90, 8'h00, "R1");
    chk("R1", irq, 0); chk("R1", cmdValid, 0); chk("R1", devCplReady, 1);

    // R2 list bytes, little-endian address
    wr(12'hC90, 8'h78); wr(12'hC91, 8'h56); wr(12'hC92, 8'h34); wr(12'hC93, 8'h12);
    wr(12'hC94, 8'hCD); wr(12'hC95, 8'hAB);
    chk("R5", cmdAddr, 32'h12345678); chk("R5", cmdLen, 16'hABCD);
    rd(12'hC92, 8'h34, "R2");
    wr(12'hC97, 8'hA5); rd(12'hC97, 8'hA5, "R2");
    rd(12'hC8A, 8'h00, "R2");

    // R5 submit pulse
    wr(12'hC8D, 8'h01);
    chk("R5", cmdValid, 1); chk("R4", localBell, 2'b01);
    tick(); chk("R5", cmdValid, 0);
    wr(12'hC8D, 8'h01); chk("R5", cmdValid, 0);
    devLocalClr = 2'b01; tick(); chk("R4", localBell, 2'b00);
    // R4 set wins over clear
    devLocalClr = 2'b10; wr(12'hC8D, 8'h02); chk("R4", localBell, 2'b10);
    devLocalClr = 2'b10; tick(); chk("R4", localBell, 2'b00);

    // R3 full bit and write-one-to-clear
    devFullSet = 1; tick(); rd(12'hC8F, 8'h02, "R3");
    wr(12'hC8F, 8'hFD); rd(12'hC8F, 8'h02, "R3");
    wr(12'hC8F, 8'h02); rd(12'hC8F, 8'h00, "R3");

    // R6 completion post
    devCplValid = 1; devCplAddr = 32'hCAFE0001; devCplStatus = 8'h5A;
    tick();
    devCplAddr = 32'hDEAD0000; devCplStatus = 8'h11;
    rd(12'hC8F, 8'h01, "R6"); chk("R7", devCplReady, 0); chk("R8", irq, 0);
    rd(12'hC98, 8'h01, "R6"); rd(12'hC9B, 8'hCA, "R6"); rd(12'hC9E, 8'h5A, "R6");
    // R7 hold-off
    tick(); tick(); tick();
    rd(12'hC98, 8'h01, "R7"); rd(12'hC9E, 8'h5A, "R7");

    // R8 interrupt enables
    wr(12'hC89, 8'h01); chk("R8", irq, 0);
    wr(12'hC8E, 8'h01); chk("R8", irq, 1);
    wr(12'hC8E, 8'h00); chk("R8", irq, 0);
    wr(12'hC8E, 8'h01); chk("R8", irq, 1);

    // R7 host clear, then held post accepted next cycle
    wr(12'hC8F, 8'h01);
    rd(12'hC8F, 8'h00, "R7"); chk("R7", devCplReady, 1); chk("R8", irq, 0);
    tick(); devCplValid = 0;
    rd(12'hC8F, 8'h01, "R7"); rd(12'hC98, 8'h00, "R7");
    rd(12'hC9B, 8'hDE, "R7"); rd(12'hC9E, 8'h11, "R7");

    // mixed traffic, checked by the model every cycle
    for (int n = 0; n < 600; n++) begin
      logic [11:0] pick [0:9];
      pick = '{12'hC89, 12'hC8C, 12'hC8D, 12'hC8E, 12'hC8F,
               12'hC90, 12'hC94, 12'hC97, 12'hC98, 12'hC9E};
      hostAddr     = pick[$urandom_range(0, 9)];
      hostWrData   = 8'($urandom);
      hostWrEn     = ($urandom_range(0, 2) == 0);
      devLocalClr  = 2'($urandom);
      devFullSet   = ($urandom_range(0, 7) == 0);
      devCplValid  = ($urandom_range(0, 1) == 1);
      devCplAddr   = $urandom;
      devCplStatus = 8'($urandom);
      @(negedge clk); #1;
    end
    hostWrEn = 0; devCplValid = 0;
    tick();
    report();
  end
endmodule